// File: doc/BRIEF.md
# Byte-stream framer with XOR header check

The block turns a stream of bytes into fixed-length frames. Each byte offered with a valid strobe is written into the next position of a frame buffer. A frame is `HSIZE` header bytes, then `DSIZE` payload bytes, then one check byte. When the last position is written, the whole frame is copied into a hold register and collection starts again at position 0.

Two stages then run side by side on the held frame. The verifier folds the header bytes together with XOR, one byte per cycle, starting from zero, and compares the result with the check byte. The forwarder owns the frame from the moment it is handed over. It publishes the frame with a one-cycle `out_valid` unless the verifier's verdict is a mismatch. On a mismatch it drops the frame and raises a one-cycle `chk_fail` instead.

Bytes that arrive while a frame is being verified and forwarded go into the next frame and are not lost. The design assumes that successive frames are at least `HSIZE + 3` accepted bytes apart, which holds by construction because `SIZE = HSIZE + DSIZE + 1` and `DSIZE >= 2`.

Top module: `byte_framer`

## Requirements
- R1: After reset, `out_valid` and `chk_fail` are low, and the first accepted byte goes to frame position 0.
- R2: Byte k of a frame, counting from 0 in arrival order, appears on `out_frame[8k+7:8k]`. `out_frame` is stable during the cycle in which `out_valid` is high.
- R3: For a frame whose check matches, `out_valid` is high for exactly one cycle, on the clock edge that comes `HSIZE + 2` edges after the edge that accepted the frame's last byte.
- R4: The check passes when the XOR of bytes 0 to `HSIZE-1` equals byte `SIZE-1`, where `SIZE = HSIZE + DSIZE + 1`. Payload bytes do not enter the check.
- R5: For a frame whose check fails, `chk_fail` pulses for one cycle at the same point in time that `out_valid` would have had, and `out_valid` is not raised for that frame.
- R6: `out_valid` and `chk_fail` are never high in the same cycle.
- R7: After a full frame, collection resumes at position 0. Bytes accepted while the previous frame is still being checked or forwarded belong to the next frame.
- R8: A byte is captured only on a cycle with `in_valid` high. Idle cycles, whatever `in_byte` carries, do not advance the frame.
- R9: The XOR accumulator starts from zero for every frame, so a verdict does not depend on any earlier frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | `in_byte` holds a byte to capture this cycle |
| in_byte | input | 8 | Incoming stream byte |
| out_valid | output | 1 | One-cycle pulse: `out_frame` holds a frame whose check matched |
| out_frame | output | 8*SIZE | Held frame, byte k on bits 8k+7:8k |
| chk_fail | output | 1 | One-cycle pulse: the frame's check did not match and it was dropped |

## Verification
Two things can happen in the same cycle. The verifier can deliver its verdict while the forwarder is still ready to publish, and a fresh byte of the next frame can be captured while that verdict turns into `out_valid` or `chk_fail`. The bench provokes both by sending frames back to back with no idle cycles, mixing frames that have a corrupted check byte with good ones, and inserting random idle gaps that carry junk data. A bench model computes the expected verdict and the expected edge from the bytes it sent. Each cycle is then judged: it must show a single good pulse with the exact frame, a single failure pulse, or silence, as the model expects.

// File: rtl/framer_pkg.sv
// framer_pkg: shared byte type and width for the framer blocks.
package framer_pkg;
    localparam int BYTE_W = 8;
    typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/framer_collect.sv
// framer_collect: writes accepted bytes into positions 0..SIZE-1 in arrival
// order. When the last position is written, it copies the whole frame into a
// hold register and pulses rdy_o one cycle later.
// Assumes: the consumers are done with the held frame before the next frame
// completes (the next frame is at least SIZE accepted bytes away).
module framer_collect
    import framer_pkg::*;
#(
    parameter int SIZE = 13
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  byte_t                in_byte,
    output logic [SIZE*BYTE_W-1:0] frame_o,
    output logic                 rdy_o
);
    localparam int CW = (SIZE > 1) ? $clog2(SIZE) : 1;

    logic [CW-1:0] pos_q;
    byte_t         slot_q [SIZE-1];
    logic          last_w;
    logic [SIZE*BYTE_W-1:0] full_w;

    assign last_w = in_valid && (pos_q == CW'(SIZE-1));

    // Assemble the finished frame: stored slots plus the byte arriving now.
    always_comb begin
        for (int i = 0; i < SIZE-1; i++) begin
            full_w[i*BYTE_W +: BYTE_W] = slot_q[i];
        end
        full_w[(SIZE-1)*BYTE_W +: BYTE_W] = in_byte;
    end

    // Position counter: advances per accepted byte, wraps after the check byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q <= '0;
        end else if (in_valid) begin
            pos_q <= last_w ? '0 : pos_q + 1'b1;
        end
    end

    // Slot storage for positions 0..SIZE-2.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < SIZE-1; i++) slot_q[i] <= '0;
        end else if (in_valid && !last_w) begin
            slot_q[pos_q] <= in_byte;
        end
    end

    // Hold register and ready pulse for the completed frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_o <= '0;
            rdy_o   <= 1'b0;
        end else begin
            rdy_o <= last_w;
            if (last_w) frame_o <= full_w;
        end
    end
endmodule

// File: rtl/framer_check.sv
// framer_check: folds the header bytes with XOR, one byte per cycle, from an
// accumulator cleared at each start, and compares the result with the check
// byte. Pulses done_o with bad_o on the cycle after the last header byte.
// Assumes: hdr_i and chk_i stay stable from start_i until done_o.
module framer_check
    import framer_pkg::*;
#(
    parameter int HSIZE = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start_i,
    input  logic [HSIZE*BYTE_W-1:0] hdr_i,
    input  byte_t                   chk_i,
    output logic                    done_o,
    output logic                    bad_o
);
    localparam int IW = (HSIZE > 1) ? $clog2(HSIZE) : 1;

    logic [IW-1:0] idx_q;
    byte_t         acc_q;
    logic          busy_q;
    byte_t         cur_w;
    byte_t         fold_w;

    assign cur_w  = hdr_i[idx_q*BYTE_W +: BYTE_W];
    assign fold_w = acc_q ^ cur_w;

    // Header walk: clear on start, fold one byte per busy cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q  <= '0;
            acc_q  <= '0;
            busy_q <= 1'b0;
        end else if (start_i) begin
            idx_q  <= '0;
            acc_q  <= '0;
            busy_q <= 1'b1;
        end else if (busy_q) begin
            acc_q <= fold_w;
            if (idx_q == IW'(HSIZE-1)) begin
                busy_q <= 1'b0;
                idx_q  <= '0;
            end else begin
                idx_q <= idx_q + 1'b1;
            end
        end
    end

    // Verdict register: one-cycle done with the compare result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_o <= 1'b0;
            bad_o  <= 1'b0;
        end else begin
            done_o <= busy_q && !start_i && (idx_q == IW'(HSIZE-1));
            bad_o  <= fold_w != chk_i;
        end
    end
endmodule

// File: rtl/framer_fwd.sv
// framer_fwd: takes ownership of a handed-over frame and publishes it on the
// verifier's verdict. A failing verdict cancels the publication and turns it
// into a failure pulse instead.
// Assumes: exactly one verdict arrives per handed-over frame.
module framer_fwd (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic done_i,
    input  logic bad_i,
    output logic out_valid_o,
    output logic fail_o
);
    logic active_q;

    // Ownership flag: set on hand-over, cleared once the verdict is used.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
        end else if (start_i) begin
            active_q <= 1'b1;
        end else if (done_i) begin
            active_q <= 1'b0;
        end
    end

    // Output pulses: publish a good frame, or abort and flag a bad one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid_o <= 1'b0;
            fail_o      <= 1'b0;
        end else begin
            out_valid_o <= active_q && done_i && !bad_i;
            fail_o      <= active_q && done_i && bad_i;
        end
    end
endmodule

// File: rtl/byte_framer.sv
// byte_framer: top of the framer. Collection, header verification and
// forwarding run as concurrent stages on one held frame.
// Assumes: DSIZE >= 2, so a frame is released before the next one completes.
module byte_framer
    import framer_pkg::*;
#(
    parameter int HSIZE = 4,
    parameter int DSIZE = 8,
    localparam int SIZE = HSIZE + DSIZE + 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    input  logic [7:0]             in_byte,
    output logic                   out_valid,
    output logic [SIZE*8-1:0]      out_frame,
    output logic                   chk_fail
);
    logic [SIZE*BYTE_W-1:0] frame_w;
    logic                   rdy_w;
    logic                   chk_done;
    logic                   chk_bad;

    framer_collect #(.SIZE(SIZE)) collect_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_byte  (in_byte),
        .frame_o  (frame_w),
        .rdy_o    (rdy_w)
    );

    framer_check #(.HSIZE(HSIZE)) check_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (rdy_w),
        .hdr_i   (frame_w[HSIZE*BYTE_W-1:0]),
        .chk_i   (frame_w[SIZE*BYTE_W-1 -: BYTE_W]),
        .done_o  (chk_done),
        .bad_o   (chk_bad)
    );

    framer_fwd fwd_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (rdy_w),
        .done_i      (chk_done),
        .bad_i       (chk_bad),
        .out_valid_o (out_valid),
        .fail_o      (chk_fail)
    );

    assign out_frame = frame_w;
endmodule

// File: rtl/byte_framer_sva.sv
// byte_framer_sva: protocol checks on the framer outputs and on the verdict
// hand-off between the verifier and the forwarder.
module byte_framer_sva #(
    parameter int HSIZE = 4,
    parameter int DSIZE = 8,
    localparam int SIZE = HSIZE + DSIZE + 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              out_valid,
    input logic              chk_fail,
    input logic [SIZE*8-1:0] out_frame,
    input logic              chk_done,
    input logic              chk_bad
);
    AST_OUT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid); // R3
    AST_FAIL_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        chk_fail |=> !chk_fail); // R5
    AST_NEVER_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_valid && chk_fail)); // R6
    AST_GOOD_PUBLISHED: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_done && !chk_bad) |=> out_valid); // R4
    AST_BAD_ABORTS: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_done && chk_bad) |=> (chk_fail && !out_valid)); // R5
    AST_FRAME_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $stable(out_frame)); // R2
endmodule

bind byte_framer byte_framer_sva #(.HSIZE(HSIZE), .DSIZE(DSIZE)) sva_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .out_valid (out_valid),
    .chk_fail  (chk_fail),
    .out_frame (out_frame),
    .chk_done  (chk_done),
    .chk_bad   (chk_bad)
);

// File: tb/byte_framer_tb_top.sv
`timescale 1ns/1ps
module byte_framer_tb_top;
    localparam int HSIZE = 4;
    localparam int DSIZE = 8;
    localparam int SIZE  = HSIZE + DSIZE + 1;
    localparam int FW    = SIZE*8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [7:0]    in_byte = 8'h00;
    logic          out_valid;
    logic [FW-1:0] out_frame;
    logic          chk_fail;

    int n_cmp = 0;
    int n_bad = 0;
    int ncnt = 0;
    bit finished = 0;

    // model state
    logic [FW-1:0] m_buf = '0;
    int            m_pos = 0;
    bit            pend = 0;
    int            pend_due = 0;
    bit            pend_bad = 0;
    logic [FW-1:0] pend_frame = '0;
    string         pend_tag = "R3";

    always #2 clk = ~clk;

    byte_framer #(.HSIZE(HSIZE), .DSIZE(DSIZE)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
        .out_valid(out_valid), .out_frame(out_frame), .chk_fail(chk_fail)
    );

    function automatic logic [7:0] hdr_xor(input logic [FW-1:0] f);
        logic [7:0] x = 8'h00;
        for (int i = 0; i < HSIZE; i++) x ^= f[i*8 +: 8];
        return x;
    endfunction

    function automatic logic [FW-1:0] mk_frame(input bit corrupt);
        logic [FW-1:0] f;
        for (int i = 0; i < SIZE-1; i++) f[i*8 +: 8] = 8'($urandom);
        f[(SIZE-1)*8 +: 8] = hdr_xor(f) ^ (corrupt ? 8'(($urandom % 255) + 1) : 8'h00);
        return f;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [FW-1:0] act, input logic [FW-1:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Per-cycle judge, half a period after each rising edge.
    always @(negedge clk) begin
        ncnt++;
        if (rst_n && !finished) begin
            if (pend && ncnt == pend_due) begin
                check(out_valid == !pend_bad, pend_bad ? "R5" : pend_tag, "out_valid",
                      FW'(out_valid), FW'(!pend_bad));
                check(chk_fail == pend_bad, pend_bad ? "R5" : "R4", "chk_fail",
                      FW'(chk_fail), FW'(pend_bad));
                if (!pend_bad)
                    check(out_frame == pend_frame, "R2", "out_frame", out_frame, pend_frame);
                pend = 0;
            end else if (out_valid || chk_fail) begin
                check(1'b0, "R6", "unexpected pulse (valid,fail)",
                      FW'({out_valid, chk_fail}), FW'(0));
            end
        end
    end

    task automatic put_byte(input logic [7:0] b);
        @(negedge clk); #1;
        in_valid = 1'b1;
        in_byte  = b;
        m_buf[m_pos*8 +: 8] = b;
        m_pos++;
        if (m_pos == SIZE) begin
            pend       = 1;
            pend_due   = ncnt + HSIZE + 3;
            pend_bad   = hdr_xor(m_buf) != m_buf[(SIZE-1)*8 +: 8];
            pend_frame = m_buf;
            m_pos      = 0;
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); #1;
            in_valid = 1'b0;
            in_byte  = 8'($urandom); // R8: junk on idle cycles
        end
    endtask

    task automatic send_frame(input logic [FW-1:0] f, input int gapmax);
        for (int i = 0; i < SIZE; i++) begin
            if (gapmax > 0) idle($urandom % (gapmax + 1));
            put_byte(f[i*8 +: 8]);
        end
    endtask

    initial begin
        logic [FW-1:0] f;
        void'($urandom(32'd1234));
        repeat (4) @(negedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk); #1;
        check(out_valid == 0, "R1", "out_valid after reset", FW'(out_valid), FW'(0));
        check(chk_fail == 0, "R1", "chk_fail after reset", FW'(chk_fail), FW'(0));

        // R1/R3: first good frame lands from position 0
        send_frame(mk_frame(0), 0);
        idle(12);
        // R5: corrupted check byte aborts forwarding
        send_frame(mk_frame(1), 0);
        idle(12);
        // R9: good frame right after a bad one
        send_frame(mk_frame(0), 0);
        idle(12);
        // R4: payload changes do not matter; header all ones, check 0x00
        f = mk_frame(0);
        for (int i = 0; i < HSIZE; i++) f[i*8 +: 8] = 8'hFF;
        f[(SIZE-1)*8 +: 8] = 8'h00;
        send_frame(f, 0);
        idle(12);
        // R4: single header bit flipped turns the frame bad
        f[0] = ~f[0];
        send_frame(f, 0);
        idle(12);
        // R8: random idle gaps with junk data
        send_frame(mk_frame(0), 3);
        idle(12);
        // R7: back-to-back frames, next frame overlaps verdict and forwarding
        pend_tag = "R7";
        for (int k = 0; k < 6; k++) send_frame(mk_frame(k % 3 == 1), 0);
        idle(12);
        // random mix
        pend_tag = "R3";
        for (int k = 0; k < 60; k++) send_frame(mk_frame(($urandom % 3) == 0), $urandom % 3);
        idle(15);
        check(pend == 0, "R3", "verdict still outstanding", FW'(pend), FW'(0));
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule